// File: doc/BRIEF.md
# Erase-Verify Retry Controller

This block is a host-side sequencer that erases one address region of a flash device and confirms that the erase took hold. After a start pulse it places the device in its margin-checking erase mode and erases the region. It then polls the status word until the erase has finished, with an extra two-read confirmation, and reads every word of the region back. If a word is not fully erased, the block erases again and continues from the failing word. This repeats until every word reads blank or a retry budget runs out.

The block talks to a command agent that produces the real device waveforms. It raises a one-cycle request carrying an operation code and an address, and it does so only while the agent is not busy. The agent answers each request with a one-cycle completion pulse, and for reads it returns the data word with that pulse. The region bounds and the retry budget are parameters. The outcome appears as a one-cycle `done` pulse, with a pass or fail flag that stays valid until the next start.

Top module: `erase_verify_ctrl`

## Requirements
- R1: While `rst` is high and after it, until `start`, the outputs `busy`, `done`, `pass`, `fail` and `cmd_req` are all low.
- R2: A start first issues the mode-entry operation (op code 2), then an erase (op code 1) addressed to `START_ADDR`. Every erase adds one to the retry count, which is cleared at start.
- R3: `cmd_req` lasts a single cycle, is raised only while `mem_busy` is low, and no further request is raised until `mem_done` answers the previous one.
- R4: After each erase, status reads (op code 0) go to `START_ADDR`. A read is a completion hint when its bit 7 is 1, the erased value, or when its bit 6 equals bit 6 of the previous status read. No word other than `START_ADDR` is read while the erase is still running.
- R5: A hint is accepted only if the next two status reads both return bits 7 and 6 equal to the hint read. Any mismatch discards the hint, and polling continues.
- R6: Verification reads go in ascending order from `START_ADDR` to `END_ADDR`. A word passes only if it reads 16'hFFFF.
- R7: When a word fails and the retry count is below `RETRY_MAX`, the block erases again, polls again, and resumes verification at the failing word, without re-reading the words that already passed.
- R8: When a word fails and the retry count equals `RETRY_MAX`, the run ends with `fail` high and no mode-exit operation is issued.
- R9: Once `END_ADDR` reads blank, the mode-exit operation (op code 3) is issued, and after its completion the run ends with `pass` high.
- R10: `done` is high for exactly one cycle per run, with exactly one of `pass`/`fail` set. That flag holds until the next accepted start, which clears both.
- R11: A `start` pulse while `busy` is high is ignored: it neither restarts the sequence nor changes the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase-verify run (accepted only when idle) |
| cmd_req | output | 1 | One-cycle operation request to the command agent |
| cmd_op | output | 2 | Operation: 0 read, 1 erase, 2 mode entry, 3 mode exit |
| cmd_addr | output | 20 | Word address for the operation |
| mem_busy | input | 1 | Command agent cannot accept a request |
| mem_done | input | 1 | One-cycle completion of the outstanding request |
| mem_rdata | input | 16 | Read data, valid with `mem_done` on reads |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Region verified blank, held until next start |
| fail | output | 1 | Retry budget exhausted, held until next start |

## Verification
The bench models a device whose status reads show DQ7 low and a toggling DQ6 for a chosen number of reads after each erase. A spurious DQ7-high read or a stalled DQ6 pair can be injected into that stream. A design that trusted a single hint would read the region while the erase is still running, and the model flags this. One chosen word needs a set number of erases before it reads blank. From this the bench derives the exact erase count and the number of reads outside the poll address. A controller that restarted verification at the region start after a re-erase would read more words than expected. One with an off-by-one retry limit would report the wrong erase count or the wrong outcome. Further directed cases cover a failing first word, which can only be detected through the toggle-stall path, a second start in mid-run, and the persistence of the result flags.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int POLL_BIT = 7;
    localparam int TOGGLE_BIT = 6;
    localparam logic [DATA_W-1:0] BLANK_WORD = '1;

    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_ERASE     = 2'd1,
        OP_MODE_IN   = 2'd2,
        OP_MODE_OUT  = 2'd3
    } mem_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTER, ST_ENTER_W,
        ST_ERASE, ST_ERASE_W,
        ST_POLL,  ST_POLL_W,
        ST_CHECK, ST_CHECK_W,
        ST_LEAVE, ST_LEAVE_W,
        ST_FINISH
    } ctrl_state_e;

    typedef enum logic [1:0] {
        JP_SEEK,
        JP_CONFIRM_A,
        JP_CONFIRM_B
    } judge_phase_e;

    typedef struct packed {
        mem_op_e           op;
        logic [ADDR_W-1:0] addr;
    } mem_cmd_t;

    typedef struct packed {
        logic poll;
        logic toggle;
    } status_bits_t;

    function automatic status_bits_t status_of(logic [DATA_W-1:0] w);
        status_bits_t s;
        s.poll   = w[POLL_BIT];
        s.toggle = w[TOGGLE_BIT];
        return s;
    endfunction

    function automatic logic is_blank(logic [DATA_W-1:0] w);
        return w == BLANK_WORD;
    endfunction

endpackage

// File: rtl/evr_retry_ctr.sv
module evr_retry_ctr #(
    parameter int LIMIT = 100,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_limit
);
    assign at_limit = (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/evr_addr_walk.sv
module evr_addr_walk
    import evr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FIRST = '0,
    parameter logic [ADDR_W-1:0] LAST  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    assign at_last = (addr == LAST);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            addr <= FIRST;
        end else if (step && !at_last) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/evr_poll_judge.sv
module evr_poll_judge
    import evr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sample,
    input  logic [DATA_W-1:0] rdata,
    output logic              complete
);
    judge_phase_e phase;
    status_bits_t snap;
    status_bits_t cur;
    logic         have_prev;
    logic         hint;
    logic         same;

    assign cur      = status_of(rdata);
    assign same     = (cur == snap);
    assign hint     = cur.poll || (have_prev && (cur.toggle == snap.toggle));
    assign complete = sample && (phase == JP_CONFIRM_B) && same;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase     <= JP_SEEK;
            snap      <= '0;
            have_prev <= 1'b0;
        end else if (sample) begin
            have_prev <= 1'b1;
            case (phase)
                JP_SEEK: begin
                    snap  <= cur;
                    phase <= hint ? JP_CONFIRM_A : JP_SEEK;
                end
                JP_CONFIRM_A: begin
                    snap  <= cur;
                    phase <= same ? JP_CONFIRM_B : JP_SEEK;
                end
                default: begin
                    snap  <= cur;
                    phase <= JP_SEEK;
                end
            endcase
        end
    end
endmodule

// File: rtl/erase_verify_ctrl.sv
module erase_verify_ctrl
    import evr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = 20'h00000,
    parameter logic [ADDR_W-1:0] END_ADDR   = 20'h003FF,
    parameter int                RETRY_MAX  = 100,
    localparam int               CW         = $clog2(RETRY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              mem_busy,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    ctrl_state_e       st, st_n;
    mem_cmd_t          cmd;
    logic              issue_state;
    logic              launch;
    logic              accept;
    logic [CW-1:0]     retry_cnt;
    logic              retry_full;
    logic [ADDR_W-1:0] walk_addr;
    logic              walk_last;
    logic              walk_step;
    logic              poll_ok;
    logic              judge_clr;
    logic              word_ok;
    logic              set_pass, set_fail;

    assign accept      = (st == ST_IDLE) && start;
    assign issue_state = (st == ST_ENTER) || (st == ST_ERASE) || (st == ST_POLL)
                      || (st == ST_CHECK) || (st == ST_LEAVE);
    assign launch      = issue_state && !mem_busy;
    assign word_ok     = is_blank(mem_rdata);

    always_comb begin
        cmd.addr = START_ADDR;
        case (st)
            ST_ENTER: cmd.op = OP_MODE_IN;
            ST_ERASE: cmd.op = OP_ERASE;
            ST_LEAVE: cmd.op = OP_MODE_OUT;
            ST_CHECK: begin
                cmd.op   = OP_READ;
                cmd.addr = walk_addr;
            end
            default:  cmd.op = OP_READ;
        endcase
    end

    assign cmd_req  = launch;
    assign cmd_op   = cmd.op;
    assign cmd_addr = cmd.addr;

    evr_retry_ctr #(.LIMIT(RETRY_MAX)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .inc      ((st == ST_ERASE) && launch),
        .cnt      (retry_cnt),
        .at_limit (retry_full)
    );

    assign walk_step = (st == ST_CHECK_W) && mem_done && word_ok;

    evr_addr_walk #(.FIRST(START_ADDR), .LAST(END_ADDR)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    (walk_step),
        .addr    (walk_addr),
        .at_last (walk_last)
    );

    assign judge_clr = (st == ST_ERASE_W) && mem_done;

    evr_poll_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .clr      (judge_clr),
        .sample   ((st == ST_POLL_W) && mem_done),
        .rdata    (mem_rdata),
        .complete (poll_ok)
    );

    always_comb begin
        st_n     = st;
        set_pass = 1'b0;
        set_fail = 1'b0;
        case (st)
            ST_IDLE:    if (start) st_n = ST_ENTER;
            ST_ENTER:   if (launch) st_n = ST_ENTER_W;
            ST_ENTER_W: if (mem_done) st_n = ST_ERASE;
            ST_ERASE:   if (launch) st_n = ST_ERASE_W;
            ST_ERASE_W: if (mem_done) st_n = ST_POLL;
            ST_POLL:    if (launch) st_n = ST_POLL_W;
            ST_POLL_W:  if (mem_done) st_n = poll_ok ? ST_CHECK : ST_POLL;
            ST_CHECK:   if (launch) st_n = ST_CHECK_W;
            ST_CHECK_W: begin
                if (mem_done) begin
                    if (word_ok) begin
                        st_n = walk_last ? ST_LEAVE : ST_CHECK;
                    end else if (retry_full) begin
                        st_n     = ST_FINISH;
                        set_fail = 1'b1;
                    end else begin
                        st_n = ST_ERASE;
                    end
                end
            end
            ST_LEAVE:   if (launch) st_n = ST_LEAVE_W;
            ST_LEAVE_W: begin
                if (mem_done) begin
                    st_n     = ST_FINISH;
                    set_pass = 1'b1;
                end
            end
            default:    st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            pass <= 1'b0;
            fail <= 1'b0;
        end else begin
            st <= st_n;
            if (accept) begin
                pass <= 1'b0;
                fail <= 1'b0;
            end else begin
                if (set_pass) pass <= 1'b1;
                if (set_fail) fail <= 1'b1;
            end
        end
    end

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_FINISH);

endmodule

// File: rtl/erase_verify_ctrl_chk.sv
module erase_verify_ctrl_chk
    import evr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = 20'h00000,
    parameter logic [ADDR_W-1:0] END_ADDR   = 20'h003FF,
    parameter int                RETRY_MAX  = 100,
    localparam int               CW         = $clog2(RETRY_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_req,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              mem_busy,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [CW-1:0]     retry_cnt
);
    p_req_not_busy_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> !mem_busy);

    p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_req |=> !cmd_req);

    p_read_in_region_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && cmd_op == OP_READ) |-> (cmd_addr >= START_ADDR && cmd_addr <= END_ADDR));

    p_retry_bound_r8: assert property (@(posedge clk) disable iff (rst)
        retry_cnt <= CW'(RETRY_MAX));

    p_fail_at_limit_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (retry_cnt == CW'(RETRY_MAX)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_status_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail));

    p_status_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    p_req_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> busy);
endmodule

bind erase_verify_ctrl erase_verify_ctrl_chk #(
    .START_ADDR (START_ADDR),
    .END_ADDR   (END_ADDR),
    .RETRY_MAX  (RETRY_MAX)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_req   (cmd_req),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .mem_busy  (mem_busy),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .retry_cnt (retry_cnt)
);

// File: tb/erase_verify_ctrl_tb_top.sv
module erase_verify_ctrl_tb_top;
    localparam logic [19:0] RSTART = 20'h00100;
    localparam logic [19:0] REND   = 20'h0010F;
    localparam int          RMAX   = 4;

    typedef struct packed {
        logic [3:0] bad;
        logic [3:0] need;
        logic [3:0] poll;
        logic [3:0] g7;
        logic [3:0] s6;
        logic       exp_pass;
        logic [3:0] exp_erase;
        logic [5:0] exp_ns;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{4'd0,  4'd1, 4'd3, 4'd15, 4'd15, 1'b1, 4'd1, 6'd15},
        '{4'd5,  4'd2, 4'd0, 4'd15, 4'd15, 1'b1, 4'd2, 6'd16},
        '{4'd15, 4'd4, 4'd5, 4'd15, 4'd15, 1'b1, 4'd4, 6'd18},
        '{4'd7,  4'd6, 4'd2, 4'd15, 4'd15, 1'b0, 4'd4, 6'd10},
        '{4'd0,  4'd9, 4'd1, 4'd15, 4'd15, 1'b0, 4'd4, 6'd0},
        '{4'd3,  4'd1, 4'd6, 4'd2,  4'd15, 1'b1, 4'd1, 6'd15},
        '{4'd9,  4'd3, 4'd6, 4'd15, 4'd1,  1'b1, 4'd3, 6'd17},
        '{4'd12, 4'd2, 4'd5, 4'd4,  4'd15, 1'b1, 4'd2, 6'd16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmd_req;
    logic [1:0]  cmd_op;
    logic [19:0] cmd_addr;
    logic        mem_busy = 1'b0;
    logic        mem_done = 1'b0;
    logic [15:0] mem_rdata = 16'h0000;
    logic        busy, done, pass, fail;

    int n_checks = 0;
    int n_fail   = 0;

    // device model state
    row_t        cfg;
    logic [15:0] words [16];
    int          lat = 0;
    logic [15:0] pend = 16'h0000;
    int          busy_left = 0;
    int          bidx = 0;
    logic        tog = 1'b0;
    int          erase_cnt = 0, enter_cnt = 0, exit_cnt = 0, ns_cnt = 0;
    int          premature = 0, viol = 0, op_cnt = 0;
    logic [1:0]  first_op = 2'd0;

    always #4 clk = ~clk;

    erase_verify_ctrl #(
        .START_ADDR (RSTART),
        .END_ADDR   (REND),
        .RETRY_MAX  (RMAX)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_req   (cmd_req),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .mem_busy  (mem_busy),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail      (fail)
    );

    always @(posedge clk) begin
        mem_done <= 1'b0;
        if (lat > 0) begin
            lat = lat - 1;
            if (lat == 0) begin
                mem_done  <= 1'b1;
                mem_rdata <= pend;
                mem_busy  <= 1'b0;
            end
        end
        if (cmd_req) begin
            if (mem_busy || lat != 0) viol = viol + 1;
            if (op_cnt == 0) first_op = cmd_op;
            op_cnt = op_cnt + 1;
            pend = 16'h0000;
            case (cmd_op)
                2'd0: begin
                    if (busy_left > 0) begin
                        pend = {8'h00, (bidx == int'(cfg.g7)), tog, 6'h00};
                        if (bidx != int'(cfg.s6)) tog = ~tog;
                        bidx = bidx + 1;
                        busy_left = busy_left - 1;
                        if (cmd_addr != RSTART) premature = premature + 1;
                    end else begin
                        pend = words[cmd_addr[3:0]];
                    end
                    if (cmd_addr != RSTART) ns_cnt = ns_cnt + 1;
                end
                2'd1: begin
                    erase_cnt = erase_cnt + 1;
                    for (int k = 0; k < 16; k++) begin
                        if (k != int'(cfg.bad) || erase_cnt >= int'(cfg.need)) words[k] = 16'hFFFF;
                    end
                    busy_left = int'(cfg.poll);
                    bidx = 0;
                    tog = 1'b0;
                end
                2'd2: enter_cnt = enter_cnt + 1;
                default: exit_cnt = exit_cnt + 1;
            endcase
            lat = 2;
            mem_busy <= 1'b1;
        end
    end

    task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_model(input row_t r);
        cfg = r;
        for (int k = 0; k < 16; k++) words[k] = 16'h0000;
        erase_cnt = 0; enter_cnt = 0; exit_cnt = 0; ns_cnt = 0;
        premature = 0; op_cnt = 0; busy_left = 0; bidx = 0; tog = 1'b0;
    endtask

    task automatic run_row(input row_t r, input logic second_start);
        int guard;
        load_model(r);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: result flags cleared by an accepted start
        check(!pass && !fail && busy, "R10", "flags cleared at start", {pass, fail}, 0);
        guard = 0;
        while (!done && guard < 20000) begin
            if (second_start && guard == 30) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check(pass == r.exp_pass && fail == !r.exp_pass, "R8/R9", "outcome pass flag", pass, r.exp_pass);
        check(erase_cnt == int'(r.exp_erase), "R7", "erase count", erase_cnt, r.exp_erase);
        check(exit_cnt == int'(r.exp_pass), "R9", "exit ops", exit_cnt, r.exp_pass);
        check(enter_cnt == 1 && first_op == 2'd2, "R2", "entry ops first", enter_cnt, 1);
        check(ns_cnt == int'(r.exp_ns), "R6", "reads outside poll address", ns_cnt, r.exp_ns);
        check(premature == 0, "R5", "reads during erase", premature, 0);
        check(viol == 0, "R3", "request overlap", viol, 0);
        @(negedge clk);
        check(done == 1'b0, "R10", "done width", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pass && !fail && !cmd_req, "R1", "outputs in reset",
              {busy, done, pass, fail, cmd_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !pass && !fail && !cmd_req, "R1", "idle after reset",
              {busy, done, pass, fail, cmd_req}, 0);

        // R4 R5 R6 R7 R8 R9: table walk
        for (int i = 0; i < 8; i++) begin
            run_row(ROWS[i], 1'b0);
        end

        // R11: start in mid-run ignored
        run_row(ROWS[1], 1'b1);

        // R10: flags persist across idle cycles
        repeat (20) @(negedge clk);
        check(pass == 1'b1 && !fail && !done && !busy, "R10", "pass held while idle", pass, 1);
        run_row(ROWS[4], 1'b0);
        repeat (15) @(negedge clk);
        check(fail == 1'b1 && !pass, "R10", "fail held while idle", fail, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule